// File: doc/BRIEF.md
# Single-Cycle Core Debug Controller

This block gives a simple non-pipelined RV32 core run-control debug. It decodes the SYSTEM-opcode instructions that a debug ROM relies on: the three register-source CSR instructions, ebreak and dret. It holds the four core debug CSRs and a debug-mode flag, and it rejects any touch of those CSRs from normal execution. Every cycle it selects where the core fetches next. The choices are the next sequential word, the branch or jump target, the debug halt address, and the saved debug PC.

The core feeds the block the instruction it is executing, that instruction's PC, the branch target, the branch, zero and jump flags, the register value addressed by rs1, and the external halt request. The block returns a 2-bit select for the core's four-input next-PC mux, the halted flag, the saved debug PC, and an illegal-instruction flag. For CSR reads it also returns the old CSR value and a write-back strobe for rd. A halt lets the current instruction finish. Fetch then moves to the halt address, and the block records where normal execution would have gone next.

Top module: `scdbg_ctrl`

## Requirements
- R1: After reset `halted` is 0, `dpc` is 0, both scratch CSRs read 0, and dcsr reads 0x4000_0003 in every bit except the cause field dcsr[8:6].
- R2: Outside debug mode a halt is entered when `halt_req` is 1, when an ebreak executes while dcsr bit 15 is 1, or when a single-step is pending. An ebreak with dcsr bit 15 at 0 has no effect: `pc_sel` stays 00 and `halted` stays 0.
- R3: `pc_sel` is 10 on halt entry or on an ebreak in debug mode, otherwise 11 on a dret in debug mode, otherwise 01 when `jump` is 1 or when `branch` and `zero` are both 1, otherwise 00. A halt therefore wins over a taken branch.
- R4: On halt entry `dpc` takes the next PC the instruction would have produced: `target` if taken, else `pc`+4. `halted` rises on the following cycle.
- R5: A dret in debug mode drives `pc_sel` to 11, and `halted` falls on the next cycle. Outside debug mode a dret has no effect.
- R6: ebreak is 0x00100073 and dret is 0x7B200073 (opcode 1110011, funct3 000, rs1 = rd = 0). An ebreak in debug mode redirects to the halt address and leaves the debug mode and `dpc` unchanged. Neither instruction asserts `csr_wb`.
- R7: funct3 001 writes the rs1 value, 010 sets the bits given by the rs1 value, and 011 clears those bits. The old value appears on `csr_rdata` with `csr_wb` = 1. For 010 or 011 with an rs1 field of 0 the CSR is not written.
- R8: The CSR addresses are dcsr 0x7B0, dpc 0x7B1, scratch 0x7B2 and 0x7B3, and each is separate storage. A CSR access outside debug mode, any other CSR address, or a SYSTEM instruction with funct3 1xx or an unknown funct3 000 form raises `illegal`. In all these cases `csr_wb` is 0 and no CSR changes.
- R9: Bit 2 of dcsr is the step control. A dret taken with that bit at 1 lets exactly one instruction execute, then halts. With the bit at 0 no further halt follows.
- R10: Each halt entry writes its cause to dcsr[8:6]: 1 for ebreak, 3 for halt request, 4 for step. The precedence is ebreak, then halt request, then step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 32 | Instruction executing this cycle |
| pc | input | 32 | PC of that instruction |
| target | input | 32 | Branch or jump target of that instruction |
| branch | input | 1 | Instruction is a conditional branch |
| zero | input | 1 | Branch condition holds |
| jump | input | 1 | Instruction is an unconditional jump |
| halt_req | input | 1 | External request to enter debug mode |
| rs1_val | input | 32 | Register file value read through rs1 |
| pc_sel | output | 2 | Next-PC select: 00 seq, 01 target, 10 halt address, 11 dpc |
| halted | output | 1 | Core is in debug mode |
| dpc | output | 32 | Saved debug PC |
| illegal | output | 1 | Illegal SYSTEM instruction or guarded CSR access |
| csr_wb | output | 1 | Write `csr_rdata` into rd this cycle |
| csr_rdata | output | 32 | Old value of the accessed CSR |

## Verification
The assertions check on every cycle that a halt request outside debug mode selects the halt address, sets the mode and captures pc+4 when nothing is taken. They also check that a dret in debug mode selects dpc and leaves the mode, that an ebreak in debug mode keeps the mode and `dpc`, that a CSR access outside debug mode is flagged, and that a flagged instruction never writes back. The bench scenarios cover what only a sequence shows. These are the read-modify-write results of the CSR operations, the cause field after each kind of halt, and the precedence between causes. They also include the exactly-one-instruction behaviour of single-step, and the ebreak and dret cases that must have no effect.

// File: rtl/scdbg_pkg.sv
package scdbg_pkg;

  localparam int XLEN = 32;
  localparam int NUM_SCRATCH = 2;

  localparam logic [6:0]  OPC_SYSTEM = 7'b1110011;
  localparam logic [11:0] IMM_EBREAK = 12'h001;
  localparam logic [11:0] IMM_DRET   = 12'h7B2;

  localparam logic [11:0] CSR_DCSR = 12'h7B0;

  localparam logic [31:0] DCSR_RESET    = 32'h4000_0003;
  localparam int          DCSR_STEP_BIT = 2;
  localparam int          DCSR_EBM_BIT  = 15;
  localparam int          DCSR_CAUSE_LO = 6;
  localparam int          DCSR_CAUSE_HI = 8;

  typedef enum logic [1:0] {
    PCSEL_SEQ  = 2'b00,
    PCSEL_TGT  = 2'b01,
    PCSEL_HALT = 2'b10,
    PCSEL_DPC  = 2'b11
  } pcsel_e;

  typedef enum logic [1:0] {
    CSROP_NONE = 2'd0,
    CSROP_RW   = 2'd1,
    CSROP_SET  = 2'd2,
    CSROP_CLR  = 2'd3
  } csrop_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_EBREAK  = 3'd1,
    CAUSE_HALTREQ = 3'd3,
    CAUSE_STEP    = 3'd4
  } cause_e;

  typedef struct packed {
    logic        csr;
    csrop_e      op;
    logic [11:0] addr;
    logic        src_zero;
    logic        ebreak;
    logic        dret;
    logic        bad;
  } dec_t;

endpackage

// File: rtl/scdbg_decode.sv
module scdbg_decode
  import scdbg_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [6:0]  opcode;
  logic [4:0]  rd_f;
  logic [2:0]  f3;
  logic [4:0]  rs1_f;
  logic [11:0] imm;

  assign opcode = instr[6:0];
  assign rd_f   = instr[11:7];
  assign f3     = instr[14:12];
  assign rs1_f  = instr[19:15];
  assign imm    = instr[31:20];

  always_comb begin
    dec          = '0;
    dec.op       = CSROP_NONE;
    dec.addr     = imm;
    dec.src_zero = (rs1_f == 5'd0);
    if (opcode == OPC_SYSTEM) begin
      unique case (f3)
        3'b000: begin
          if (rs1_f == 5'd0 && rd_f == 5'd0 && imm == IMM_EBREAK)
            dec.ebreak = 1'b1;
          else if (rs1_f == 5'd0 && rd_f == 5'd0 && imm == IMM_DRET)
            dec.dret = 1'b1;
          else
            dec.bad = 1'b1;
        end
        3'b001: begin dec.csr = 1'b1; dec.op = CSROP_RW;  end
        3'b010: begin dec.csr = 1'b1; dec.op = CSROP_SET; end
        3'b011: begin dec.csr = 1'b1; dec.op = CSROP_CLR; end
        default: dec.bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/scdbg_csr.sv
module scdbg_csr
  import scdbg_pkg::*;
#(
  parameter int XLEN_P      = XLEN,
  parameter int SCRATCH_CNT = NUM_SCRATCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              acc,
  input  csrop_e            op,
  input  logic [11:0]       addr,
  input  logic              src_zero,
  input  logic [XLEN_P-1:0] rs1_val,
  input  logic              enter,
  input  logic [2:0]        cause,
  input  logic [XLEN_P-1:0] nat_next,
  output logic [XLEN_P-1:0] rdata,
  output logic              wb,
  output logic              acc_illegal,
  output logic [XLEN_P-1:0] dpc,
  output logic              step,
  output logic              ebreakm
);

  localparam int          NUM_CSR  = 2 + SCRATCH_CNT;
  localparam logic [11:0] OFF_DCSR = 12'd0;
  localparam logic [11:0] OFF_DPC  = 12'd1;

  logic [11:0]       off;
  logic              in_range;
  logic              legal;
  logic              we;
  logic [XLEN_P-1:0] old_val;
  logic [XLEN_P-1:0] wdata;
  logic [XLEN_P-1:0] scr_vals [SCRATCH_CNT];

  logic [XLEN_P-1:0] dcsr_q, dcsr_d;
  logic              dcsr_en;
  logic [XLEN_P-1:0] dpc_q, dpc_d;
  logic              dpc_en;

  assign off         = addr - CSR_DCSR;
  assign in_range    = (off < 12'(NUM_CSR));
  assign legal       = acc && in_range && dbg_mode;
  assign acc_illegal = acc && !legal;
  assign we          = legal && ((op == CSROP_RW) || !src_zero);
  assign wb          = legal;
  assign rdata       = legal ? old_val : '0;

  // read mux over the selected CSR
  always_comb begin
    old_val = '0;
    if (off == OFF_DCSR) old_val = dcsr_q;
    if (off == OFF_DPC)  old_val = dpc_q;
    for (int i = 0; i < SCRATCH_CNT; i++) begin
      if (off == 12'(2 + i)) old_val = scr_vals[i];
    end
  end

  // read-modify-write value
  always_comb begin
    unique case (op)
      CSROP_SET: wdata = old_val | rs1_val;
      CSROP_CLR: wdata = old_val & ~rs1_val;
      default:   wdata = rs1_val;
    endcase
  end

  // dcsr: cause on entry, software write in debug mode
  always_comb begin
    dcsr_d  = dcsr_q;
    dcsr_en = 1'b0;
    if (enter) begin
      dcsr_d[DCSR_CAUSE_HI:DCSR_CAUSE_LO] = cause;
      dcsr_en = 1'b1;
    end else if (we && off == OFF_DCSR) begin
      dcsr_d  = wdata;
      dcsr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcsr_q <= XLEN_P'(DCSR_RESET);
    else if (dcsr_en) dcsr_q <= dcsr_d;
  end

  // dpc: capture on entry, software write in debug mode
  always_comb begin
    dpc_d  = dpc_q;
    dpc_en = 1'b0;
    if (enter) begin
      dpc_d  = nat_next;
      dpc_en = 1'b1;
    end else if (we && off == OFF_DPC) begin
      dpc_d  = wdata;
      dpc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dpc_q <= '0;
    else if (dpc_en) dpc_q <= dpc_d;
  end

  // scratch registers
  for (genvar i = 0; i < SCRATCH_CNT; i++) begin : g_scr
    logic [XLEN_P-1:0] scr_q;
    logic              scr_en;
    assign scr_en = we && (off == 12'(2 + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      scr_q <= '0;
      else if (scr_en) scr_q <= wdata;
    end
    assign scr_vals[i] = scr_q;
  end

  assign dpc     = dpc_q;
  assign step    = dcsr_q[DCSR_STEP_BIT];
  assign ebreakm = dcsr_q[DCSR_EBM_BIT];

endmodule

// File: rtl/scdbg_run.sv
module scdbg_run
  import scdbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_ebreak,
  input  logic       is_dret,
  input  logic       halt_req,
  input  logic       taken,
  input  logic       ebreakm,
  input  logic       step,
  output logic       dbg_mode,
  output logic       enter,
  output logic [2:0] cause,
  output pcsel_e     pc_sel
);

  logic mode_q, mode_d;
  logic step_pend_q, step_pend_d;
  logic ebreak_halt;
  logic dret_go;

  assign ebreak_halt = is_ebreak && ebreakm;
  assign enter       = !mode_q && (halt_req || ebreak_halt || step_pend_q);
  assign dret_go     = mode_q && is_dret;

  // cause precedence: ebreak, halt request, step
  always_comb begin
    if (ebreak_halt)   cause = CAUSE_EBREAK;
    else if (halt_req) cause = CAUSE_HALTREQ;
    else               cause = CAUSE_STEP;
  end

  always_comb begin
    mode_d = mode_q;
    if (enter)        mode_d = 1'b1;
    else if (dret_go) mode_d = 1'b0;
  end

  always_comb begin
    step_pend_d = step_pend_q;
    if (enter)                step_pend_d = 1'b0;
    else if (dret_go && step) step_pend_d = 1'b1;
  end

  // next-PC select priority: halt/park, dret, taken, sequential
  always_comb begin
    if (enter || (mode_q && is_ebreak)) pc_sel = PCSEL_HALT;
    else if (dret_go)                   pc_sel = PCSEL_DPC;
    else if (taken)                     pc_sel = PCSEL_TGT;
    else                                pc_sel = PCSEL_SEQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= 1'b0;
      step_pend_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      step_pend_q <= step_pend_d;
    end
  end

  assign dbg_mode = mode_q;

endmodule

// File: rtl/scdbg_ctrl.sv
module scdbg_ctrl
  import scdbg_pkg::*;
#(
  parameter int XLEN_P = XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr,
  input  logic [XLEN_P-1:0] pc,
  input  logic [XLEN_P-1:0] target,
  input  logic              branch,
  input  logic              zero,
  input  logic              jump,
  input  logic              halt_req,
  input  logic [XLEN_P-1:0] rs1_val,
  output logic [1:0]        pc_sel,
  output logic              halted,
  output logic [XLEN_P-1:0] dpc,
  output logic              illegal,
  output logic              csr_wb,
  output logic [XLEN_P-1:0] csr_rdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  dec_t              dec;
  logic              taken;
  logic [XLEN_P-1:0] nat_next;
  logic              dbg_mode;
  logic              enter;
  logic [2:0]        cause;
  pcsel_e            sel;
  logic              step;
  logic              ebreakm;
  logic              acc_illegal;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign taken    = jump || (branch && zero);
  assign nat_next = taken ? target : (pc + XLEN_P'(4));

  scdbg_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  scdbg_run u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .is_ebreak (dec.ebreak),
    .is_dret   (dec.dret),
    .halt_req  (halt_req),
    .taken     (taken),
    .ebreakm   (ebreakm),
    .step      (step),
    .dbg_mode  (dbg_mode),
    .enter     (enter),
    .cause     (cause),
    .pc_sel    (sel)
  );

  scdbg_csr #(
    .XLEN_P      (XLEN_P),
    .SCRATCH_CNT (NUM_SCRATCH)
  ) u_csr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .dbg_mode    (dbg_mode),
    .acc         (dec.csr),
    .op          (dec.op),
    .addr        (dec.addr),
    .src_zero    (dec.src_zero),
    .rs1_val     (rs1_val),
    .enter       (enter),
    .cause       (cause),
    .nat_next    (nat_next),
    .rdata       (csr_rdata),
    .wb          (csr_wb),
    .acc_illegal (acc_illegal),
    .dpc         (dpc),
    .step        (step),
    .ebreakm     (ebreakm)
  );

  assign pc_sel  = sel;
  assign halted  = dbg_mode;
  assign illegal = dec.bad || acc_illegal;

endmodule

// File: rtl/scdbg_ctrl_chk.sv
module scdbg_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic        branch,
  input logic        zero,
  input logic        jump,
  input logic        halt_req,
  input logic [1:0]  pc_sel,
  input logic        halted,
  input logic [31:0] dpc,
  input logic        illegal,
  input logic        csr_wb
);

  localparam logic [31:0] DRET_W   = 32'h7B20_0073;
  localparam logic [31:0] EBREAK_W = 32'h0010_0073;

  logic csr_form;
  assign csr_form = (instr[6:0] == 7'b1110011) && !instr[14] && (instr[13:12] != 2'b00);

  p_haltreq_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt_req) |-> pc_sel == 2'b10);

  p_enter_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt_req) |=> halted);

  p_dpc_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt_req && !jump && !(branch && zero)) |=> dpc == $past(pc) + 32'd4);

  p_dret_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && instr == DRET_W) |-> pc_sel == 2'b11);

  p_dret_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && instr == DRET_W) |=> !halted);

  p_park_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && instr == EBREAK_W) |=> (halted && $stable(dpc)));

  p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && csr_form) |-> illegal);

  p_illegal_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !csr_wb);

endmodule

bind scdbg_ctrl scdbg_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .instr    (instr),
  .pc       (pc),
  .branch   (branch),
  .zero     (zero),
  .jump     (jump),
  .halt_req (halt_req),
  .pc_sel   (pc_sel),
  .halted   (halted),
  .dpc      (dpc),
  .illegal  (illegal),
  .csr_wb   (csr_wb)
);

// File: tb/scdbg_ctrl_bench.sv
module scdbg_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  localparam logic [31:0] NOP    = 32'h0000_0013;
  localparam logic [31:0] EBREAK = 32'h0010_0073;
  localparam logic [31:0] DRET   = 32'h7B20_0073;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr, pc, target, rs1_val;
  logic        branch, zero, jump, halt_req;
  logic [1:0]  pc_sel;
  logic        halted, illegal, csr_wb;
  logic [31:0] dpc, csr_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scdbg_ctrl u_scdbg_ctrl (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .target(target),
    .branch(branch), .zero(zero), .jump(jump), .halt_req(halt_req),
    .rs1_val(rs1_val), .pc_sel(pc_sel), .halted(halted), .dpc(dpc),
    .illegal(illegal), .csr_wb(csr_wb), .csr_rdata(csr_rdata)
  );

  function automatic logic [31:0] csr_i(input logic [2:0] f3, input logic [11:0] a,
                                        input logic [4:0] rs1, input logic [4:0] rd);
    return {a, rs1, f3, rd, 7'b1110011};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] i, input logic [31:0] p);
    instr = i; pc = p; branch = 1'b0; zero = 1'b0; jump = 1'b0;
    halt_req = 1'b0; target = 32'h0; rs1_val = 32'h0;
    #1;
  endtask

  // read a CSR without writing it (set-bits form with rs1 field 0)
  task automatic rd_csr(input logic [11:0] a, output logic [31:0] v);
    drive(csr_i(3'b010, a, 5'd0, 5'd1), 32'h0);
    v = csr_rdata;
    tick();
  endtask

  task automatic wr_csr(input logic [2:0] f3, input logic [11:0] a, input logic [31:0] v);
    instr = csr_i(f3, a, 5'd9, 5'd0); rs1_val = v;
    #1;
    tick();
  endtask

  task automatic t_reset();
    drive(NOP, 32'h0);
    chk("R1 halted after reset", {31'd0, halted}, 32'd0);
    chk("R1 dpc after reset", dpc, 32'h0);
    chk("R3 seq select", {30'd0, pc_sel}, 32'd0);
  endtask

  task automatic t_run_select();
    drive(NOP, 32'h40); branch = 1'b1; zero = 1'b1; #1;
    chk("R3 taken branch select", {30'd0, pc_sel}, 32'd1);
    zero = 1'b0; #1;
    chk("R3 untaken branch select", {30'd0, pc_sel}, 32'd0);
    branch = 1'b0; jump = 1'b1; #1;
    chk("R3 jump select", {30'd0, pc_sel}, 32'd1);
    drive(EBREAK, 32'h44);
    chk("R2 ebreak without enable select", {30'd0, pc_sel}, 32'd0);
    tick();
    chk("R2 ebreak without enable no halt", {31'd0, halted}, 32'd0);
    drive(DRET, 32'h48);
    chk("R5 dret outside select", {30'd0, pc_sel}, 32'd0);
    tick();
    chk("R5 dret outside no effect", {31'd0, halted}, 32'd0);
    drive(csr_i(3'b001, 12'h7B2, 5'd5, 5'd1), 32'h4C); rs1_val = 32'hDEAD_BEEF; #1;
    chk("R8 guard illegal", {31'd0, illegal}, 32'd1);
    chk("R8 guard no writeback", {31'd0, csr_wb}, 32'd0);
    tick();
  endtask

  task automatic t_halt_req();
    logic [31:0] v;
    drive(NOP, 32'h100); halt_req = 1'b1; #1;
    chk("R2 halt request select", {30'd0, pc_sel}, 32'd2);
    tick();
    drive(NOP, 32'h0);
    chk("R4 halted after request", {31'd0, halted}, 32'd1);
    chk("R4 dpc sequential", dpc, 32'h104);
    rd_csr(12'h7B0, v);
    chk("R10 cause halt request", {29'd0, v[8:6]}, 32'd3);
    chk("R1 dcsr reset bits", v & ~32'h1C0, 32'h4000_0003);
  endtask

  task automatic t_csr_ops();
    logic [31:0] v;
    drive(csr_i(3'b001, 12'h7B2, 5'd5, 5'd3), 32'h0); rs1_val = 32'hA5A5_0000; #1;
    chk("R1 scratch0 reset", csr_rdata, 32'h0);
    chk("R7 writeback strobe", {31'd0, csr_wb}, 32'd1);
    tick();
    drive(csr_i(3'b010, 12'h7B2, 5'd6, 5'd3), 32'h0); rs1_val = 32'h0000_00FF; #1;
    chk("R7 read-write result", csr_rdata, 32'hA5A5_0000);
    tick();
    drive(csr_i(3'b011, 12'h7B2, 5'd7, 5'd3), 32'h0); rs1_val = 32'hA500_0000; #1;
    chk("R7 set result", csr_rdata, 32'hA5A5_00FF);
    tick();
    drive(csr_i(3'b011, 12'h7B2, 5'd0, 5'd3), 32'h0); rs1_val = 32'hFFFF_FFFF; #1;
    chk("R7 clear result", csr_rdata, 32'h00A5_00FF);
    tick();
    rd_csr(12'h7B2, v);
    chk("R7 rs1 zero no write", v, 32'h00A5_00FF);
    rd_csr(12'h7B3, v);
    chk("R8 scratch1 separate", v, 32'h0);
    drive(csr_i(3'b001, 12'h7B4, 5'd5, 5'd1), 32'h0); rs1_val = 32'h1; #1;
    chk("R8 unknown address illegal", {31'd0, illegal}, 32'd1);
    chk("R8 unknown address no wb", {31'd0, csr_wb}, 32'd0);
    tick();
    drive(csr_i(3'b101, 12'h7B2, 5'd5, 5'd1), 32'h0); #1;
    chk("R8 funct3 1xx illegal", {31'd0, illegal}, 32'd1);
    tick();
    rd_csr(12'h7B2, v);
    chk("R8 illegal leaves csr", v, 32'h00A5_00FF);
  endtask

  task automatic t_park();
    drive(EBREAK, 32'h0);
    chk("R6 ebreak in debug select", {30'd0, pc_sel}, 32'd2);
    chk("R6 ebreak no writeback", {31'd0, csr_wb}, 32'd0);
    tick();
    chk("R6 ebreak keeps mode", {31'd0, halted}, 32'd1);
    chk("R6 ebreak keeps dpc", dpc, 32'h104);
  endtask

  task automatic t_dret();
    drive(NOP, 32'h0);
    wr_csr(3'b001, 12'h7B1, 32'h200);
    chk("R7 dpc written", dpc, 32'h200);
    drive(DRET, 32'h0);
    chk("R5 dret select", {30'd0, pc_sel}, 32'd3);
    tick();
    chk("R5 dret exits", {31'd0, halted}, 32'd0);
    drive(NOP, 32'h200);
    chk("R9 no step when clear", {30'd0, pc_sel}, 32'd0);
    tick();
    chk("R9 stays running", {31'd0, halted}, 32'd0);
  endtask

  task automatic t_halt_priority();
    logic [31:0] v;
    drive(NOP, 32'h204); jump = 1'b1; target = 32'h340; halt_req = 1'b1; #1;
    chk("R3 halt over jump", {30'd0, pc_sel}, 32'd2);
    tick();
    drive(NOP, 32'h0);
    chk("R4 dpc takes target", dpc, 32'h340);
    rd_csr(12'h7B0, v);
    chk("R10 cause halt request again", {29'd0, v[8:6]}, 32'd3);
  endtask

  task automatic t_ebreakm();
    logic [31:0] v;
    drive(NOP, 32'h0);
    wr_csr(3'b010, 12'h7B0, 32'h0000_8000);
    drive(DRET, 32'h0);
    tick();
    drive(EBREAK, 32'h340); halt_req = 1'b1; #1;
    chk("R2 ebreak with enable select", {30'd0, pc_sel}, 32'd2);
    tick();
    drive(NOP, 32'h0);
    chk("R2 ebreak halts", {31'd0, halted}, 32'd1);
    chk("R4 dpc after ebreak", dpc, 32'h344);
    rd_csr(12'h7B0, v);
    chk("R10 ebreak over request", {29'd0, v[8:6]}, 32'd1);
  endtask

  task automatic t_step();
    logic [31:0] v;
    drive(NOP, 32'h0);
    wr_csr(3'b011, 12'h7B0, 32'h0000_8000);
    wr_csr(3'b010, 12'h7B0, 32'h0000_0004);
    drive(DRET, 32'h0);
    tick();
    chk("R9 left debug for step", {31'd0, halted}, 32'd0);
    drive(NOP, 32'h344);
    chk("R9 one instruction then halt", {30'd0, pc_sel}, 32'd2);
    tick();
    drive(NOP, 32'h0);
    chk("R9 halted after step", {31'd0, halted}, 32'd1);
    chk("R9 dpc after step", dpc, 32'h348);
    rd_csr(12'h7B0, v);
    chk("R10 cause step", {29'd0, v[8:6]}, 32'd4);
    drive(DRET, 32'h0);
    tick();
    drive(NOP, 32'h348); branch = 1'b1; zero = 1'b1; target = 32'h500; #1;
    tick();
    drive(NOP, 32'h0);
    chk("R9 step over taken branch", dpc, 32'h500);
    drive(DRET, 32'h0);
    tick();
    drive(NOP, 32'h500); halt_req = 1'b1; #1;
    tick();
    drive(NOP, 32'h0);
    rd_csr(12'h7B0, v);
    chk("R10 request over step", {29'd0, v[8:6]}, 32'd3);
    chk("R4 dpc with step and request", dpc, 32'h504);
    wr_csr(3'b011, 12'h7B0, 32'h0000_0004);
    drive(DRET, 32'h0);
    tick();
    drive(NOP, 32'h504);
    chk("R9 step cleared select", {30'd0, pc_sel}, 32'd0);
    tick();
    chk("R9 step cleared running", {31'd0, halted}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(NOP, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_run_select();
    t_halt_req();
    t_csr_ops();
    t_park();
    t_dret();
    t_halt_priority();
    t_ebreakm();
    t_step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule